// File: doc/BRIEF.md
# Low-Power Mode Controller

This block governs the two sleep levels of a small 8-bit microcontroller core. Software issues a single-cycle idle request or power-down request. The controller then gates the CPU clock, the peripheral clock and the oscillator. It also overrides the address-latch and program-strobe pins, and it decides whether the low address/data port floats. The decision depends on the current mode and on whether program fetch is internal or external.

Idle keeps the oscillator and the peripherals running and stops only the CPU. Any enabled interrupt ends idle, and the CPU clock reopens on the next machine-cycle boundary. A qualified hardware reset also ends idle. Power-down stops the oscillator and ignores every interrupt, so only a qualified hardware reset brings the core back.

A reset counts as qualified once the reset pin has been seen high for a set number of machine cycles while the oscillator runs. When reset ends idle, the CPU may execute briefly before the internal reset takes hold. During that window, writes to internal RAM are blocked.

Top module: `lpm_ctrl`

## Requirements
- R1: After the asynchronous reset is released, `mode_o` is 0 (run). The CPU clock, peripheral clock and oscillator enables are 1. `core_rst_o`, `ram_wr_block_o`, `pin_force_o`, `ale_lvl_o`, `psen_lvl_o` and `p0_float_o` are 0.
- R2: An idle request taken in run mode gives `mode_o`=1 after the next clock edge. In that mode the CPU clock enable is 0, and the peripheral clock and oscillator enables stay 1.
- R3: A power-down request taken in run mode gives `mode_o`=2 after the next edge. In that mode the CPU clock, peripheral clock and oscillator enables are all 0 while `rst_pin_i` is low. If both requests arrive in the same cycle, power-down wins.
- R4: In idle, an enabled interrupt (`irq_pend_i & irq_en_i` nonzero, even for one cycle) returns the block to run mode on the first machine-cycle boundary at or after the edge that samples it. Boundaries fall every CLKS_PER_MC clocks, counted from reset release while the oscillator runs.
- R5: Pending interrupts that are not enabled leave idle untouched. No interrupt ends power-down.
- R6: `core_rst_o` rises on the edge at which `rst_pin_i` has been sampled high on RST_MCS*CLKS_PER_MC consecutive edges. A shorter high pulse never raises it. It falls on the first edge that samples `rst_pin_i` low.
- R7: In idle, the first edge that samples `rst_pin_i` high gives `mode_o`=3 (reset window). In that mode the CPU clock enable is 1 and `ram_wr_block_o` is 1. The next edge after `core_rst_o` is seen high returns the block to mode 0 with `ram_wr_block_o`=0.
- R8: In power-down, `oscillator enable` follows `rst_pin_i` high without waiting for a clock edge. The mode stays 2 until `core_rst_o` is seen high, and turns to 0 on the following edge.
- R9: `pin_force_o` is 1 only in idle and power-down. Idle drives `ale_lvl_o`=`psen_lvl_o`=1, and power-down drives both to 0. With no override, both levels read 0.
- R10: `p0_float_o` is 1 only in idle or power-down with `ext_fetch_i`=1. It is 0 for internal fetch and in every other mode.
- R11: Mode requests are ignored outside run mode and while `core_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin_i | input | 1 | Synchronised hardware reset pin, active high |
| idle_req_i | input | 1 | Single-cycle idle request from a control write |
| pdown_req_i | input | 1 | Single-cycle power-down request from a control write |
| irq_pend_i | input | NIRQ | Pending interrupt requests |
| irq_en_i | input | NIRQ | Interrupt enable mask |
| ext_fetch_i | input | 1 | 1 when program fetch is external |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| core_rst_o | output | 1 | Qualified internal reset |
| ram_wr_block_o | output | 1 | Inhibits internal RAM writes |
| pin_force_o | output | 1 | Strobe pin override active |
| ale_lvl_o | output | 1 | Forced address-latch pin level |
| psen_lvl_o | output | 1 | Forced program-strobe pin level |
| p0_float_o | output | 1 | Low address/data port floats |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down, 3 reset window |

## Verification
The bench builds the block with CLKS_PER_MC=12, RST_MCS=2 and NIRQ=6. With these values, an interrupt can be placed on each of the twelve clock phases of a machine cycle, and the wake edge is predicted by rounding up to the next multiple of twelve. The 24-clock reset qualification is small enough to probe at 23 and 24 edges, and against a short pulse. Both sleep modes are crossed with both fetch sources to cover the pin overrides.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LPM_RUN    = 2'd0,
    LPM_IDLE   = 2'd1,
    LPM_PDOWN  = 2'd2,
    LPM_RSTWIN = 2'd3
  } lpm_mode_e;
endpackage

// File: rtl/lpm_mc_timer.sv
module lpm_mc_timer #(
  parameter int CLKS_PER_MC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sync_clr_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_clr_i)       cnt_d = '0;
    else if (run_i) begin
      if (cnt_q == LAST)  cnt_d = '0;
      else                cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST) && !sync_clr_i;

  // R4
  mc_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  mc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !sync_clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
  parameter int QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pin_i,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual_q, qual_d;

  always_comb begin
    cnt_d  = cnt_q;
    qual_d = qual_q;
    if (!pin_i) begin
      cnt_d  = '0;
      qual_d = 1'b0;
    end else if (run_i) begin
      if (cnt_q == LIMIT) qual_d = 1'b1;
      else                cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qual_o = qual_q;

  // R6
  rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_i |=> !qual_o);

  // R6
  rst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_o) |-> $past(pin_i));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle_req_i,
  input  logic      pdown_req_i,
  input  logic      wake_i,
  input  logic      mc_tick_i,
  input  logic      rst_pin_i,
  input  logic      core_rst_i,
  output lpm_mode_e mode_o
);
  lpm_mode_e state_q, state_d;
  logic      wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    if (core_rst_i) begin
      state_d = LPM_RUN;
      wake_d  = 1'b0;
    end else begin
      unique case (state_q)
        LPM_RUN: begin
          wake_d = 1'b0;
          if (pdown_req_i)     state_d = LPM_PDOWN;
          else if (idle_req_i) state_d = LPM_IDLE;
        end
        LPM_IDLE: begin
          if (rst_pin_i) begin
            state_d = LPM_RSTWIN;
            wake_d  = 1'b0;
          end else if ((wake_q || wake_i) && mc_tick_i) begin
            state_d = LPM_RUN;
            wake_d  = 1'b0;
          end else if (wake_i) begin
            wake_d  = 1'b1;
          end
        end
        LPM_PDOWN: begin
          state_d = LPM_PDOWN;
        end
        LPM_RSTWIN: begin
          if (!rst_pin_i) state_d = LPM_RUN;
        end
        default: state_d = LPM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LPM_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign mode_o = state_q;

  // R5
  pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_PDOWN && !core_rst_i) |=> state_q == LPM_PDOWN);

  // R4
  idle_wake_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_IDLE && !rst_pin_i && !core_rst_i && !mc_tick_i) |=> state_q == LPM_IDLE);

  // R3
  pdown_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_RUN && !core_rst_i && pdown_req_i) |=> state_q == LPM_PDOWN);

  // R7
  rstwin_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_IDLE && rst_pin_i && !core_rst_i) |=> state_q == LPM_RSTWIN);

  // R11
  req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LPM_PDOWN && !core_rst_i) |=> state_q != LPM_IDLE);
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpm_mode_e mode_i,
  input  logic      ext_fetch_i,
  input  logic      rst_pin_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      osc_en_o,
  output logic      ram_wr_block_o,
  output logic      pin_force_o,
  output logic      ale_lvl_o,
  output logic      psen_lvl_o,
  output logic      p0_float_o
);
  logic sleeping;

  always_comb begin
    cpu_clk_en_o   = 1'b1;
    per_clk_en_o   = 1'b1;
    osc_en_o       = 1'b1;
    ram_wr_block_o = 1'b0;
    pin_force_o    = 1'b0;
    ale_lvl_o      = 1'b0;
    psen_lvl_o     = 1'b0;
    sleeping       = 1'b0;
    unique case (mode_i)
      LPM_IDLE: begin
        cpu_clk_en_o = 1'b0;
        pin_force_o  = 1'b1;
        ale_lvl_o    = 1'b1;
        psen_lvl_o   = 1'b1;
        sleeping     = 1'b1;
      end
      LPM_PDOWN: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        osc_en_o     = rst_pin_i;
        pin_force_o  = 1'b1;
        sleeping     = 1'b1;
      end
      LPM_RSTWIN: begin
        ram_wr_block_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign p0_float_o = sleeping && ext_fetch_i;

  // R10
  p0_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p0_float_o |-> (ext_fetch_i && pin_force_o));

  // R9
  strobe_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_force_o |-> (ale_lvl_o == psen_lvl_o));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MCS     = 2,
  parameter int NIRQ        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin_i,
  input  logic            idle_req_i,
  input  logic            pdown_req_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            ext_fetch_i,
  output logic            cpu_clk_en_o,
  output logic            per_clk_en_o,
  output logic            osc_en_o,
  output logic            core_rst_o,
  output logic            ram_wr_block_o,
  output logic            pin_force_o,
  output logic            ale_lvl_o,
  output logic            psen_lvl_o,
  output logic            p0_float_o,
  output logic [1:0]      mode_o
);
  import lpm_pkg::*;

  localparam int QUAL_CLKS = RST_MCS * CLKS_PER_MC;

  logic      mc_tick;
  logic      wake_any;
  logic      core_rst;
  lpm_mode_e mode;

  assign wake_any = |(irq_pend_i & irq_en_i);

  lpm_mc_timer #(.CLKS_PER_MC(CLKS_PER_MC)) u_mc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (osc_en_o),
    .sync_clr_i (core_rst),
    .tick_o     (mc_tick)
  );

  lpm_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_rq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (osc_en_o),
    .pin_i  (rst_pin_i),
    .qual_o (core_rst)
  );

  lpm_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req_i  (idle_req_i),
    .pdown_req_i (pdown_req_i),
    .wake_i      (wake_any),
    .mc_tick_i   (mc_tick),
    .rst_pin_i   (rst_pin_i),
    .core_rst_i  (core_rst),
    .mode_o      (mode)
  );

  lpm_pin_ctrl u_pin (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode),
    .ext_fetch_i    (ext_fetch_i),
    .rst_pin_i      (rst_pin_i),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .osc_en_o       (osc_en_o),
    .ram_wr_block_o (ram_wr_block_o),
    .pin_force_o    (pin_force_o),
    .ale_lvl_o      (ale_lvl_o),
    .psen_lvl_o     (psen_lvl_o),
    .p0_float_o     (p0_float_o)
  );

  assign core_rst_o = core_rst;
  assign mode_o     = mode;
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int MC   = 12;
  localparam int NIRQ = 6;
  localparam int QUAL = 24;

  logic clk = 1'b0;
  logic rst_n, rst_pin, idle_req, pdown_req, ext_fetch;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic cpu_en, per_en, osc_en, core_rst, ram_blk, force_o, ale, psen, p0f;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  int ecount = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.CLKS_PER_MC(MC), .RST_MCS(2), .NIRQ(NIRQ)) dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin), .idle_req_i(idle_req),
    .pdown_req_i(pdown_req), .irq_pend_i(irq_pend), .irq_en_i(irq_en),
    .ext_fetch_i(ext_fetch), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .osc_en_o(osc_en), .core_rst_o(core_rst), .ram_wr_block_o(ram_blk),
    .pin_force_o(force_o), .ale_lvl_o(ale), .psen_lvl_o(psen),
    .p0_float_o(p0f), .mode_o(mode)
  );

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; idle_req = 1'b0; pdown_req = 1'b0;
    ext_fetch = 1'b0; irq_pend = '0; irq_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 cpu_en", cpu_en, 1);
    chk("R1 per_en", per_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 core_rst", core_rst, 0);
    chk("R1 ram_blk", ram_blk, 0);
    chk("R1 force", {force_o, ale, psen, p0f}, 0);

    // R4 wake sweep over every phase of the machine cycle
    for (int ph = 0; ph < MC; ph++) begin
      ext_fetch = ph[0];
      idle_req = 1'b1;
      step();
      idle_req = 1'b0;
      chk("R2 idle mode", mode, 1);
      chk("R2 cpu_en", cpu_en, 0);
      chk("R2 per_en", per_en, 1);
      chk("R2 osc_en", osc_en, 1);
      chk("R9 idle strobes", {force_o, ale, psen}, 7);
      chk("R10 idle p0 float", p0f, ph % 2);
      while (((ecount + 1) % MC) != ph) step();
      begin
        int j, e;
        j = ecount + 1;
        e = ((j + MC - 1) / MC) * MC;
        irq_en = '1;
        irq_pend = NIRQ'(1) << (ph % NIRQ);
        step();
        irq_pend = '0;
        for (int n = 0; n < MC + 2 && cpu_en == 1'b0; n++) step();
        chk("R4 wake edge", ecount, e);
        chk("R4 run after wake", mode, 0);
        chk("R9 run no force", {force_o, ale, psen, p0f}, 0);
      end
    end

    // R5 masked interrupts do not wake idle
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
    irq_en = '0;
    irq_pend = '1;
    repeat (30) step();
    chk("R5 masked idle holds", mode, 1);
    // R11 power-down request while idle ignored
    pdown_req = 1'b1;
    step();
    pdown_req = 1'b0;
    chk("R11 pdown req in idle", mode, 1);
    irq_pend = '0;
    irq_en = '1;
    irq_pend[0] = 1'b1;
    repeat (MC + 1) step();
    irq_pend = '0;
    chk("R4 unmasked wake", mode, 0);

    // R3 simultaneous requests: power-down wins
    ext_fetch = 1'b1;
    idle_req = 1'b1;
    pdown_req = 1'b1;
    step();
    idle_req = 1'b0;
    pdown_req = 1'b0;
    chk("R3 pdown mode", mode, 2);
    chk("R3 gates off", {cpu_en, per_en, osc_en}, 0);
    chk("R9 pdown strobes", {force_o, ale, psen}, 4);
    chk("R10 pdown ext float", p0f, 1);
    ext_fetch = 1'b0;
    #1;
    chk("R10 pdown int no float", p0f, 0);

    // R5 / R11 nothing leaves power-down but reset
    irq_pend = '1;
    repeat (20) step();
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
    irq_pend = '0;
    chk("R5 pdown ignores irq", mode, 2);
    chk("R11 idle req in pdown", mode, 2);

    // R8 reset exit from power-down
    rst_pin = 1'b1;
    #1;
    chk("R8 osc restart", osc_en, 1);
    repeat (QUAL - 1) step();
    chk("R6 not yet at 23", core_rst, 0);
    chk("R8 still pdown", mode, 2);
    step();
    chk("R6 qualified at 24", core_rst, 1);
    chk("R8 pdown held until seen", mode, 2);
    step();
    chk("R8 run after reset", mode, 0);
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
    chk("R11 req during core reset", mode, 0);
    rst_pin = 1'b0;
    step();
    chk("R6 fall after pin low", core_rst, 0);

    // R6 short pulse never qualifies
    rst_pin = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        step();
        seen = seen | int'(core_rst);
      end
      chk("R6 short pulse", seen, 0);
    end
    rst_pin = 1'b0;
    step();

    // R7 idle ended by reset: RAM write window
    ext_fetch = 1'b1;
    idle_req = 1'b1;
    step();
    idle_req = 1'b0;
    chk("R2 idle again", mode, 1);
    rst_pin = 1'b1;
    step();
    chk("R7 window mode", mode, 3);
    chk("R7 cpu running", cpu_en, 1);
    chk("R7 ram blocked", ram_blk, 1);
    chk("R10 window no float", {force_o, p0f}, 0);
    repeat (QUAL - 1) step();
    chk("R7 core reset in window", core_rst, 1);
    chk("R7 block held", ram_blk, 1);
    step();
    chk("R7 back to run", mode, 0);
    chk("R7 block released", ram_blk, 0);
    rst_pin = 1'b0;
    step();
    chk("R6 released", core_rst, 0);

    summary();
  end
endmodule